// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block turns a 32-bit virtual address into a physical address for one request per cycle. It holds a set of cached translations. Each entry pairs a virtual page number and an address-space tag with a physical page number and a few control bits. Every entry is compared with the request at the same time. The answer comes back in the same cycle as the request, as exactly one of four outcomes: hit, miss, write-protection fault or address error.

Each entry carries an address-space tag, so switching between processes does not require a flush. The top three bits of the address select the region. Two of the kernel regions bypass the table and map straight onto physical memory, one cached and one uncached. The block does not walk page tables. A miss is reported to the requester, and a software handler then installs the missing entry at an index it chooses, through a write port. Separate controls clear one entry, every entry, or every entry that belongs to one address space.

Top module: `tlb_xlate`

## Requirements
- R1: After synchronous reset, every entry is invalid, so any lookup in a translated region reports a miss.
- R2: A lookup hits when a valid entry has the request's page number (address bits 31:12) and the current address-space tag. The physical address is then the entry's physical page number above the unchanged 12-bit offset, and the cached flag is 1.
- R3: An entry whose address-space tag differs from the current tag never matches, even when its page number is equal.
- R4: Address bits 31:29 select the region. Patterns 0xx (user) and 11x (kernel virtual) are translated through the table. Pattern 100 is the direct cached kernel region and pattern 101 is the direct uncached kernel region.
- R5: A kernel-mode request to pattern 100 or 101 hits without consulting the table. Its physical address is the virtual address with bits 31:29 cleared. The cached flag is 1 for 100 and 0 for 101.
- R6: A user-mode request (kernel input 0) to pattern 100 or 101 reports only an address error.
- R7: A store that matches an entry completes as a hit only if the entry's rights bit is 1 (read/write) and its dirty bit is 1. Otherwise the store reports a write-protection fault. Loads ignore both bits.
- R8: When several valid entries match, the one with the lowest index supplies the translation.
- R9: A write at a given index installs the supplied page number, tag, physical page, dirty, referenced, valid and rights bits there, replacing the old content. The new entry is used from the next cycle.
- R10: Single-entry invalidation clears only the entry at the given index.
- R11: Invalidate-all clears every entry in one cycle.
- R12: Invalidate-by-tag clears, in one cycle, every entry whose tag equals the given tag, and leaves the other entries untouched.
- R13: While a request is valid, exactly one of hit, miss, write fault and address error is 1. While no request is present, all four flags, the cached flag and the physical address are 0. Whenever hit is 0, the physical address and the cached flag are 0.
- R14: When any invalidation selects an entry in the same cycle as a write to that entry, the entry ends up invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A lookup request is present |
| req_vaddr | input | 32 | Virtual address of the request |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_kernel | input | 1 | 1 when the requester runs in kernel mode |
| cur_asid | input | 6 | Address-space tag of the running process |
| wr_en | input | 1 | Install an entry this cycle |
| wr_index | input | 6 | Entry index to write |
| wr_vpn | input | 20 | Virtual page number to install |
| wr_asid | input | 6 | Address-space tag to install |
| wr_ppn | input | 20 | Physical page number to install |
| wr_dirty | input | 1 | Dirty bit to install |
| wr_refd | input | 1 | Referenced bit to install |
| wr_valid | input | 1 | Valid bit to install |
| wr_rw | input | 1 | Rights bit to install: 1 read/write, 0 read-only |
| inv_one | input | 1 | Invalidate the entry at inv_index |
| inv_index | input | 6 | Entry index for single invalidation |
| inv_all | input | 1 | Invalidate every entry |
| inv_asid_en | input | 1 | Invalidate every entry tagged inv_asid |
| inv_asid | input | 6 | Tag for invalidation by tag |
| resp_hit | output | 1 | Translation succeeded |
| resp_miss | output | 1 | No matching entry in a translated region |
| resp_wprot | output | 1 | Store refused by rights or dirty bit |
| resp_addr_err | output | 1 | User-mode access to a direct kernel region |
| resp_cached | output | 1 | The access may be cached |
| resp_paddr | output | 32 | Physical address, valid with resp_hit |

## Verification
The checker assumes that the request inputs stay stable from the point where they are driven until the sampling point of that cycle. It also assumes that nothing is written into the table while reset is active, because the invalidate-all property looks one cycle ahead under the same reset guard. The bench changes inputs only just after the rising edge and samples between edges. It keeps every control pulse to one cycle and holds all write and invalidate controls low during reset. Random traffic draws page numbers from a small pool, so that duplicate entries, tag collisions and invalidations that meet writes occur often.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W   = 32;
    localparam int OFS_W  = 12;
    localparam int VPN_W  = VA_W - OFS_W;
    localparam int PPN_W  = 20;
    localparam int PA_W   = PPN_W + OFS_W;
    localparam int ASID_W = 6;
    localparam int SEG_W  = 3;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
        logic              dirty;
        logic              refd;
        logic              rw;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        SEG_MAPPED,
        SEG_KCACHED,
        SEG_KUNCACHED
    } seg_e;

    function automatic seg_e seg_of(input logic [SEG_W-1:0] top);
        seg_e s;
        casez (top)
            3'b100:  s = SEG_KCACHED;
            3'b101:  s = SEG_KUNCACHED;
            default: s = SEG_MAPPED;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    parameter int IDX_W = $clog2(N_ENT)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_index,
    input  tlb_entry_t              wr_entry,
    input  logic                    inv_one,
    input  logic [IDX_W-1:0]        inv_index,
    input  logic                    inv_all,
    input  logic                    inv_asid_en,
    input  logic [ASID_W-1:0]       inv_asid,
    output tlb_entry_t [N_ENT-1:0]  ents
);

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        logic kill;
        assign kill = inv_all
                    | (inv_asid_en && ents[i].asid == inv_asid)
                    | (inv_one && inv_index == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ents[i].valid <= 1'b0;
            end else if (kill) begin
                ents[i].valid <= 1'b0;
            end else if (wr_en && wr_index == IDX_W'(i)) begin
                ents[i] <= wr_entry;
            end
        end
    end

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64
) (
    input  tlb_entry_t [N_ENT-1:0] ents,
    input  logic [VPN_W-1:0]       vpn,
    input  logic [ASID_W-1:0]      asid,
    output logic                   found,
    output tlb_entry_t             sel
);

    logic [N_ENT-1:0] match;

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign match[i] = ents[i].valid
                        && ents[i].vpn  == vpn
                        && ents[i].asid == asid;
    end

    // Scan from the top so the lowest matching index is the last to assign.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match[i]) begin
                found = 1'b1;
                sel   = ents[i];
            end
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int N_ENT = 64,
    parameter int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_store,
    input  logic              req_kernel,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic              wr_dirty,
    input  logic              wr_refd,
    input  logic              wr_valid,
    input  logic              wr_rw,
    input  logic              inv_one,
    input  logic [IDX_W-1:0]  inv_index,
    input  logic              inv_all,
    input  logic              inv_asid_en,
    input  logic [ASID_W-1:0] inv_asid,
    output logic              resp_hit,
    output logic              resp_miss,
    output logic              resp_wprot,
    output logic              resp_addr_err,
    output logic              resp_cached,
    output logic [PA_W-1:0]   resp_paddr
);

    tlb_entry_t [N_ENT-1:0] ents;
    tlb_entry_t             wr_entry;
    tlb_entry_t             sel;
    logic                   found;
    seg_e                   seg;
    logic                   unused_sel_refd;

    assign wr_entry = '{valid: wr_valid, vpn: wr_vpn, asid: wr_asid,
                        ppn: wr_ppn, dirty: wr_dirty, refd: wr_refd,
                        rw: wr_rw};

    tlb_store #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_index    (wr_index),
        .wr_entry    (wr_entry),
        .inv_one     (inv_one),
        .inv_index   (inv_index),
        .inv_all     (inv_all),
        .inv_asid_en (inv_asid_en),
        .inv_asid    (inv_asid),
        .ents        (ents)
    );

    tlb_cam #(.N_ENT(N_ENT)) u_cam (
        .ents  (ents),
        .vpn   (req_vaddr[VA_W-1:OFS_W]),
        .asid  (cur_asid),
        .found (found),
        .sel   (sel)
    );

    assign seg             = seg_of(req_vaddr[VA_W-1 -: SEG_W]);
    assign unused_sel_refd = sel.refd;

    always_comb begin
        resp_hit      = 1'b0;
        resp_miss     = 1'b0;
        resp_wprot    = 1'b0;
        resp_addr_err = 1'b0;
        resp_cached   = 1'b0;
        resp_paddr    = '0;
        if (req_valid) begin
            if (seg == SEG_MAPPED) begin
                if (!found) begin
                    resp_miss = 1'b1;
                end else if (req_store && !(sel.rw && sel.dirty)) begin
                    resp_wprot = 1'b1;
                end else begin
                    resp_hit    = 1'b1;
                    resp_cached = 1'b1;
                    resp_paddr  = {sel.ppn, req_vaddr[OFS_W-1:0]};
                end
            end else if (!req_kernel) begin
                resp_addr_err = 1'b1;
            end else begin
                resp_hit    = 1'b1;
                resp_cached = (seg == SEG_KCACHED);
                resp_paddr  = PA_W'({{SEG_W{1'b0}}, req_vaddr[VA_W-SEG_W-1:0]});
            end
        end
    end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_vaddr,
    input logic        req_kernel,
    input logic        inv_all,
    input logic        resp_hit,
    input logic        resp_miss,
    input logic        resp_wprot,
    input logic        resp_addr_err,
    input logic        resp_cached,
    input logic [31:0] resp_paddr
);

    logic direct_seg;
    assign direct_seg = (req_vaddr[31:30] == 2'b10);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> $onehot({resp_hit, resp_miss, resp_wprot, resp_addr_err})); // R13

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !(resp_hit || resp_miss || resp_wprot || resp_addr_err
                         || resp_cached) && resp_paddr == 32'h0); // R13

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        resp_hit |-> resp_paddr[11:0] == req_vaddr[11:0]); // R2

    AST_DIRECT_MAP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kernel && direct_seg) |->
            (resp_hit && resp_paddr == {3'b000, req_vaddr[28:0]}
             && resp_cached == !req_vaddr[29])); // R5

    AST_USER_DIRECT_ERR: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_kernel && direct_seg) |-> resp_addr_err); // R6

    AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (rst)
        inv_all |=> (!(req_valid && !direct_seg) || resp_miss)); // R11

endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_kernel    (req_kernel),
    .inv_all       (inv_all),
    .resp_hit      (resp_hit),
    .resp_miss     (resp_miss),
    .resp_wprot    (resp_wprot),
    .resp_addr_err (resp_addr_err),
    .resp_cached   (resp_cached),
    .resp_paddr    (resp_paddr)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;

    localparam int CLK_P = 10;
    localparam int NE    = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_store, req_kernel;
    logic [31:0] req_vaddr;
    logic [5:0]  cur_asid;
    logic        wr_en, wr_dirty, wr_refd, wr_valid, wr_rw;
    logic [5:0]  wr_index, wr_asid, inv_index, inv_asid;
    logic [19:0] wr_vpn, wr_ppn;
    logic        inv_one, inv_all, inv_asid_en;
    logic        resp_hit, resp_miss, resp_wprot, resp_addr_err, resp_cached;
    logic [31:0] resp_paddr;

    always #(CLK_P/2) clk = ~clk;

    tlb_xlate uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_store(req_store), .req_kernel(req_kernel), .cur_asid(cur_asid),
        .wr_en(wr_en), .wr_index(wr_index), .wr_vpn(wr_vpn), .wr_asid(wr_asid),
        .wr_ppn(wr_ppn), .wr_dirty(wr_dirty), .wr_refd(wr_refd),
        .wr_valid(wr_valid), .wr_rw(wr_rw), .inv_one(inv_one),
        .inv_index(inv_index), .inv_all(inv_all), .inv_asid_en(inv_asid_en),
        .inv_asid(inv_asid), .resp_hit(resp_hit), .resp_miss(resp_miss),
        .resp_wprot(resp_wprot), .resp_addr_err(resp_addr_err),
        .resp_cached(resp_cached), .resp_paddr(resp_paddr)
    );

    // behavioural reference state
    bit        m_val [NE];
    bit [19:0] m_vpn [NE];
    bit [5:0]  m_asid[NE];
    bit [19:0] m_ppn [NE];
    bit        m_dirty[NE];
    bit        m_rw  [NE];

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    task automatic compare(input string tag);
        bit e_hit = 0, e_miss = 0, e_wp = 0, e_ae = 0, e_c = 0;
        bit [31:0] e_pa = 0;
        int first = -1;
        if (req_valid) begin
            if (req_vaddr[31:30] == 2'b10) begin
                if (!req_kernel) e_ae = 1;
                else begin
                    e_hit = 1;
                    e_pa  = req_vaddr & 32'h1FFF_FFFF;
                    e_c   = !req_vaddr[29];
                end
            end else begin
                for (int i = 0; i < NE; i++)
                    if (first < 0 && m_val[i] && m_vpn[i] == req_vaddr[31:12]
                        && m_asid[i] == cur_asid) first = i;
                if (first < 0) e_miss = 1;
                else if (req_store && !(m_rw[first] && m_dirty[first])) e_wp = 1;
                else begin
                    e_hit = 1;
                    e_c   = 1;
                    e_pa  = {m_ppn[first], req_vaddr[11:0]};
                end
            end
        end
        n_cmp++;
        if ({resp_hit, resp_miss, resp_wprot, resp_addr_err, resp_cached, resp_paddr}
            !== {e_hit, e_miss, e_wp, e_ae, e_c, e_pa}) begin
            n_bad++;
            $display("FAIL %s: got hit=%b miss=%b wp=%b ae=%b c=%b pa=%h exp hit=%b miss=%b wp=%b ae=%b c=%b pa=%h",
                     tag, resp_hit, resp_miss, resp_wprot, resp_addr_err, resp_cached,
                     resp_paddr, e_hit, e_miss, e_wp, e_ae, e_c, e_pa);
        end
    endtask

    task automatic model_edge();
        for (int i = 0; i < NE; i++) begin
            if (rst) m_val[i] = 0;
            else if (inv_all || (inv_asid_en && m_asid[i] == inv_asid)
                     || (inv_one && inv_index == i[5:0])) m_val[i] = 0;
            else if (wr_en && wr_index == i[5:0]) begin
                m_val[i] = wr_valid; m_vpn[i] = wr_vpn; m_asid[i] = wr_asid;
                m_ppn[i] = wr_ppn; m_dirty[i] = wr_dirty; m_rw[i] = wr_rw;
            end
        end
    endtask

    task automatic tick(input string tag);
        @(negedge clk);
        compare(tag);
        @(posedge clk);
        model_edge();
        #1;
        wr_en = 0; inv_one = 0; inv_all = 0; inv_asid_en = 0;
    endtask

    task automatic look(input logic [31:0] va, input logic [5:0] id,
                        input logic st, input logic kern, input string tag);
        req_valid = 1; req_vaddr = va; cur_asid = id; req_store = st; req_kernel = kern;
        tick(tag);
    endtask

    task automatic put(input int idx, input logic [19:0] vpn, input logic [5:0] id,
                       input logic [19:0] ppn, input logic d, input logic rw);
        wr_en = 1; wr_index = idx[5:0]; wr_vpn = vpn; wr_asid = id; wr_ppn = ppn;
        wr_dirty = d; wr_refd = 1; wr_valid = 1; wr_rw = rw;
        req_valid = 0;
        tick("R9");
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; req_valid = 0; req_vaddr = 0; req_store = 0; req_kernel = 0;
        cur_asid = 0; wr_en = 0; wr_index = 0; wr_vpn = 0; wr_asid = 0; wr_ppn = 0;
        wr_dirty = 0; wr_refd = 0; wr_valid = 0; wr_rw = 0; inv_one = 0;
        inv_index = 0; inv_all = 0; inv_asid_en = 0; inv_asid = 0;
        repeat (2) @(posedge clk);
        model_edge();
        #1;
        rst = 0;
        tick("R13 idle");
        look(32'h0040_0123, 6'd0, 0, 0, "R1 reset miss");
        look(32'hC001_0040, 6'd0, 0, 1, "R1 reset miss kernel");

        put(5, 20'h00400, 6'd3, 20'h12345, 1, 1);
        look(32'h0040_0ABC, 6'd3, 0, 0, "R2 hit");
        look(32'h0040_0ABC, 6'd3, 1, 0, "R7 store rw dirty hit");
        look(32'h0040_0ABC, 6'd4, 0, 0, "R3 tag mismatch");

        put(6, 20'hC0010, 6'd3, 20'h0BEEF, 1, 1);
        look(32'hC001_0004, 6'd3, 0, 1, "R4 kernel mapped");
        look(32'hE001_0004, 6'd3, 0, 1, "R4 kernel mapped miss");

        look(32'h8123_4567, 6'd3, 0, 1, "R5 direct cached");
        look(32'hA123_4567, 6'd3, 1, 1, "R5 direct uncached");
        look(32'h8000_0000, 6'd3, 0, 0, "R6 user direct");
        look(32'hBFFF_FFFF, 6'd3, 1, 0, "R6 user direct uncached");

        put(7, 20'h00500, 6'd3, 20'h00555, 1, 0);
        look(32'h0050_0010, 6'd3, 1, 0, "R7 readonly store");
        look(32'h0050_0010, 6'd3, 0, 0, "R7 readonly load");
        put(8, 20'h00600, 6'd3, 20'h00666, 0, 1);
        look(32'h0060_0010, 6'd3, 1, 0, "R7 clean store");
        look(32'h0060_0010, 6'd3, 0, 0, "R7 clean load");

        put(20, 20'h00700, 6'd3, 20'hAAAAA, 1, 1);
        put(10, 20'h00700, 6'd3, 20'hBBBBB, 1, 1);
        look(32'h0070_0FFF, 6'd3, 0, 0, "R8 lowest index");
        put(10, 20'h00800, 6'd3, 20'hCCCCC, 1, 1);
        look(32'h0070_0FFF, 6'd3, 0, 0, "R9 overwrite");
        look(32'h0080_0001, 6'd3, 0, 0, "R9 new page");

        req_valid = 0; inv_one = 1; inv_index = 6'd20; tick("R10");
        look(32'h0070_0FFF, 6'd3, 0, 0, "R10 one cleared");
        look(32'h0080_0001, 6'd3, 0, 0, "R10 other kept");

        put(40, 20'h00900, 6'd9, 20'h09999, 1, 1);
        req_valid = 0; inv_asid_en = 1; inv_asid = 6'd3; tick("R12");
        look(32'h0040_0ABC, 6'd3, 0, 0, "R12 tag cleared");
        look(32'h0090_0ABC, 6'd9, 0, 0, "R12 other tag kept");

        wr_en = 1; wr_index = 6'd30; wr_vpn = 20'h00A00; wr_asid = 6'd9;
        wr_ppn = 20'h0AAAA; wr_dirty = 1; wr_refd = 0; wr_valid = 1; wr_rw = 1;
        inv_one = 1; inv_index = 6'd30; req_valid = 0; tick("R14");
        look(32'h00A0_0000, 6'd9, 0, 0, "R14 invalidation wins");

        req_valid = 0; inv_all = 1; tick("R11");
        look(32'h0090_0ABC, 6'd9, 0, 0, "R11 all cleared");

        for (int k = 0; k < 3000; k++) begin
            int r = int'($urandom_range(0, 99));
            logic [2:0] top = 3'($urandom_range(0, 7));
            logic [19:0] vpn = {top, 15'd0, 2'($urandom_range(0, 3))};
            req_valid  = ($urandom_range(0, 9) != 0);
            req_vaddr  = {vpn, 12'($urandom)};
            req_store  = 1'($urandom);
            req_kernel = 1'($urandom);
            cur_asid   = 6'($urandom_range(0, 2));
            if (r < 30) begin
                wr_en = 1; wr_index = 6'($urandom);
                wr_vpn = {3'($urandom_range(0, 7)), 15'd0, 2'($urandom_range(0, 3))};
                wr_asid = 6'($urandom_range(0, 2)); wr_ppn = 20'($urandom);
                wr_dirty = 1'($urandom); wr_refd = 1'($urandom);
                wr_valid = ($urandom_range(0, 7) != 0); wr_rw = 1'($urandom);
            end
            if (r >= 90 && r < 95) begin inv_one = 1; inv_index = 6'($urandom); end
            if (r == 95) inv_all = 1;
            if (r >= 96) begin inv_asid_en = 1; inv_asid = 6'($urandom_range(0, 2)); end
            tick("R2/R8/R13 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule